// File: doc/BRIEF.md
# Oversampled Frame-Sync UART Receiver

This block receives 8-N-1 asynchronous serial characters the way a synchronous serial port captures framed words. The serial line serves as its own active-low frame sync. On every sample tick the line is sampled at three times the baud rate. A falling edge seen between two consecutive ticks starts a capture. The sample that reveals the low level is the first of a fixed 29-sample word.

From that word the block takes the middle sample of each data-bit triplet and builds a byte LSB-first. It pushes the byte into a small show-ahead receive FIFO.

The capture stops after only two of the three stop-bit samples. The block therefore re-arms during the final third of the stop bit, so a start bit that arrives one third of a bit early is still caught. A reader drains the FIFO while the not-empty flag is high. Two sticky flags, one for overflow and one for underflow, are each cleared by a write-one pulse. Both flags drive one error interrupt.

Top module: `fsync_uart_rx`

## Requirements
- R1: With `rx_en_i` high, a sample tick occurs once every 2*(`div_i`+1) clock cycles, which gives three ticks per bit when the bit lasts 6*(`div_i`+1) cycles. Bytes are received correctly for several divider values.
- R2: When idle, a capture starts on a tick whose synchronized line sample is 0 while the sample of the previous tick was 1. That low sample is sample 0 of the capture.
- R3: Counting from sample 0, data bit n (n = 0..7) is taken from sample 4+3n. In a word whose first sample is bit 28, this is bit 24-3n. The bit taken from sample 4 is placed at bit 0 of the byte (LSB first).
- R4: A capture takes exactly 29 samples and ignores falling edges inside it. Each character therefore yields exactly one byte, even for data with many high-to-low transitions.
- R5: Right after sample 28 the block is idle again. A character whose stop bit lasts only two thirds of a bit is received, and so is the character that follows it.
- R6: While `rx_en_i` is low, no ticks occur, no capture runs and nothing is pushed. A frame sent while disabled produces no byte.
- R7: The FIFO holds 8 bytes. `rd_data_o` shows the oldest byte, `rd_i` removes it, and `not_empty_o` is high exactly while bytes are stored.
- R8: A byte that arrives while 8 bytes are stored is dropped and sets the sticky flag `ovf_o`. A pulse on `clr_ovf_i` clears it; if a new overflow happens in the same cycle, the overflow wins.
- R9: Asserting `rd_i` while the FIFO is empty sets the sticky flag `unf_o`. A pulse on `clr_unf_i` clears it.
- R10: `err_irq_o` is high exactly while `ovf_o` or `unf_o` is high.
- R11: After reset the FIFO is empty and `ovf_o`, `unf_o` and `err_irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable; low stops ticks and capture |
| div_i | input | DIV_W | Sample divider; tick period is 2*(div_i+1) clocks |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| rd_i | input | 1 | Pop the oldest byte |
| rd_data_o | output | 8 | Oldest stored byte (show-ahead) |
| not_empty_o | output | 1 | FIFO holds at least one byte |
| clr_ovf_i | input | 1 | Write-one clear of the overflow flag |
| clr_unf_i | input | 1 | Write-one clear of the underflow flag |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| err_irq_o | output | 1 | Error interrupt: overflow or underflow |

## Verification
The properties assume three things about the inputs:
- `div_i` only changes while `rx_en_i` is low.
- The line's bit period is exactly three ticks, apart from the deliberately shortened stop bits.
- `rd_i` and the clear pulses are single-cycle strobes.

The stimulus changes the divider only inside a disabled window. It builds every frame from whole multiples of the tick period, and shortens the stop bit by exactly one tick when it tests early start bits. Random bytes come from a fixed seed. They are mixed with directed patterns that have all-zero, all-one and alternating data.

// File: rtl/fsync_rx_pkg.sv
package fsync_rx_pkg;
  localparam int unsigned DATA_BITS = 8;
  localparam int unsigned OSR       = 3;
  // two stop-bit samples only: 1 start*3 + 8 data*3 + 2
  localparam int unsigned WORD_LEN  = OSR * (DATA_BITS + 1) + 2;
  localparam int unsigned MID_OFS   = OSR + OSR / 2;

  typedef logic [DATA_BITS-1:0] byte_t;
  typedef logic [WORD_LEN-1:0]  word_t;

  // first sample sits at the MSB of the word
  function automatic byte_t pick_mid(input word_t w);
    byte_t b;
    for (int n = 0; n < DATA_BITS; n++) begin
      b[n] = w[WORD_LEN - 1 - MID_OFS - OSR * n];
    end
    return b;
  endfunction
endpackage

// File: rtl/fsync_rx_tick.sv
module fsync_rx_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = {div_i, 1'b1};
  assign tick_o = en_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || cnt_q >= lim) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fsync_rx_capture.sv
module fsync_rx_capture
  import fsync_rx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  tick_i,
  input  logic  line_i,
  output byte_t byte_o,
  output logic  valid_o,
  output logic  busy_o
);
  localparam int unsigned CNT_W = $clog2(WORD_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_LEN - 1);

  logic                prev_q;
  logic                busy_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [WORD_LEN-2:0] sh_q;
  byte_t               byte_q;
  logic                valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b1;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '1;
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!en_i) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
        prev_q <= line_i;
      end else if (tick_i) begin
        prev_q <= line_i;
        sh_q   <= {sh_q[WORD_LEN-3:0], line_i};
        if (busy_q) begin
          if (cnt_q == LAST) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            byte_q  <= pick_mid({sh_q, line_i});
            valid_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (prev_q && !line_i) begin
          busy_q <= 1'b1;
          cnt_q  <= CNT_W'(1);
        end
      end
    end
  end

  assign byte_o  = byte_q;
  assign valid_o = valid_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/fsync_rx_fifo.sv
module fsync_rx_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     push_data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [LVL_W-1:0] level_o,
  output logic             empty_o,
  output logic             drop_o,
  output logic             under_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] lvl_q;
  logic             do_push, do_pop;

  assign empty_o = (lvl_q == '0);
  assign do_push = push_i && (lvl_q != LVL_W'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign drop_o  = push_i && !do_push;
  assign under_o = pop_i && empty_o;
  assign head_o  = mem[rd_q];
  assign level_o = lvl_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end
endmodule

// File: rtl/fsync_uart_rx.sv
module fsync_uart_rx
  import fsync_rx_pkg::*;
#(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned FIFO_DEPTH  = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rxd_i,
  input  logic             rd_i,
  output logic [7:0]       rd_data_o,
  output logic             not_empty_o,
  input  logic             clr_ovf_i,
  input  logic             clr_unf_i,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             err_irq_o
);
  logic             line;
  logic             tick;
  logic             busy;
  logic             word_valid;
  byte_t            rx_byte;
  logic [LVL_W-1:0] level;
  logic             empty;
  logic             drop;
  logic             under;
  logic             ovf_q, unf_q;

  generate
    if (SYNC_STAGES < 2) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= 1'b1;
        else         s_q <= rxd_i;
      end
      assign line = s_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '1;
        else         s_q <= {s_q[SYNC_STAGES-2:0], rxd_i};
      end
      assign line = s_q[SYNC_STAGES-1];
    end
  endgenerate

  fsync_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_en_i),
    .div_i  (div_i),
    .tick_o (tick)
  );

  fsync_rx_capture u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (rx_en_i),
    .tick_i  (tick),
    .line_i  (line),
    .byte_o  (rx_byte),
    .valid_o (word_valid),
    .busy_o  (busy)
  );

  fsync_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_BITS)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (word_valid),
    .push_data_i (rx_byte),
    .pop_i       (rd_i),
    .head_o      (rd_data_o),
    .level_o     (level),
    .empty_o     (empty),
    .drop_o      (drop),
    .under_o     (under)
  );

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (drop)           ovf_q <= 1'b1;
      else if (clr_ovf_i) ovf_q <= 1'b0;
      if (under)          unf_q <= 1'b1;
      else if (clr_unf_i) unf_q <= 1'b0;
    end
  end

  assign not_empty_o = !empty;
  assign ovf_o       = ovf_q;
  assign unf_o       = unf_q;
  assign err_irq_o   = ovf_q | unf_q;
endmodule

// File: rtl/fsync_uart_rx_chk.sv
module fsync_uart_rx_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LVL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_en_i,
  input logic             tick_i,
  input logic             busy_i,
  input logic             word_valid_i,
  input logic [LVL_W-1:0] level_i,
  input logic             rd_i,
  input logic             not_empty_i,
  input logic             clr_ovf_i,
  input logic             ovf_i,
  input logic             unf_i,
  input logic             err_irq_i
);
  AST_NO_TICK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni) !rx_en_i |-> !tick_i); // R6
  AST_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni) !rx_en_i |=> !busy_i); // R6
  AST_START_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(busy_i) |-> $past(tick_i)); // R2
  AST_ONE_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni) word_valid_i |=> !word_valid_i); // R4
  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) level_i <= LVL_W'(DEPTH)); // R7
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni) (word_valid_i && level_i == LVL_W'(DEPTH)) |=> ovf_i); // R8
  AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (ovf_i && !clr_ovf_i) |=> ovf_i); // R8
  AST_UNF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni) (rd_i && !not_empty_i) |=> unf_i); // R9
  AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni) ($rose(ovf_i) || $rose(unf_i)) |-> err_irq_i); // R10
endmodule

bind fsync_uart_rx fsync_uart_rx_chk #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_en_i      (rx_en_i),
  .tick_i       (tick),
  .busy_i       (busy),
  .word_valid_i (word_valid),
  .level_i      (level),
  .rd_i         (rd_i),
  .not_empty_i  (not_empty_o),
  .clr_ovf_i    (clr_ovf_i),
  .ovf_i        (ovf_o),
  .unf_i        (unf_o),
  .err_irq_i    (err_irq_o)
);

// File: tb/fsync_uart_rx_test.sv
`timescale 1ns/1ps
module fsync_uart_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic [15:0] div = 16'd1;
  logic        rxd = 1'b1;
  logic        rd = 1'b0;
  logic [7:0]  rd_data;
  logic        not_empty;
  logic        clr_ovf = 1'b0;
  logic        clr_unf = 1'b0;
  logic        ovf, unf, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fsync_uart_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .div_i(div), .rxd_i(rxd),
    .rd_i(rd), .rd_data_o(rd_data), .not_empty_o(not_empty),
    .clr_ovf_i(clr_ovf), .clr_unf_i(clr_unf), .ovf_o(ovf), .unf_o(unf),
    .err_irq_o(irq)
  );

  function automatic int bit_clks(input logic [15:0] d);
    return 6 * (int'(d) + 1);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input int stop_clks);
    int bc;
    bc = bit_clks(div);
    rxd = 1'b0;
    idle(bc);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      idle(bc);
    end
    rxd = 1'b1;
    idle(stop_clks);
  endtask

  task automatic pop_check(input logic [7:0] exp, input string tag);
    check(not_empty == 1'b1, {tag, " not_empty"}, not_empty, 1);
    check(rd_data == exp, tag, rd_data, exp);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-reqs act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] burst [4];
    logic [7:0] ov [9];
    logic [7:0] dir [6];
    void'($urandom(32'h5eed_0b17));
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R11 reset state
    check(!not_empty, "R11 not_empty", not_empty, 0);
    check(!ovf, "R11 ovf", ovf, 0);
    check(!unf, "R11 unf", unf, 0);
    check(!irq, "R11 irq", irq, 0);

    // R6 disabled: frame ignored
    send(8'h3C, 12);
    idle(24);
    check(!not_empty, "R6 disabled no byte", not_empty, 0);

    rx_en = 1'b1;
    idle(30);
    // R3/R4 directed patterns, one byte per frame
    dir[0] = 8'h00; dir[1] = 8'hFF; dir[2] = 8'h55;
    dir[3] = 8'hA5; dir[4] = 8'h01; dir[5] = 8'h80;
    for (int i = 0; i < 6; i++) begin
      send(dir[i], 12);
      idle(12);
      pop_check(dir[i], "R3 directed byte");
      check(!not_empty, "R4 single byte per frame", not_empty, 0);
    end

    // R5 shortened stop bits (2/3 bit), random data back to back
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 4; i++) begin
        burst[i] = 8'($urandom);
        send(burst[i], 8);
      end
      idle(24);
      for (int i = 0; i < 4; i++) pop_check(burst[i], "R5 early start byte");
      check(!not_empty, "R7 drained", not_empty, 0);
    end

    // R1 other dividers, changed while disabled
    for (int d = 2; d <= 4; d++) begin
      rx_en = 1'b0;
      idle(2);
      div = 16'(d);
      rx_en = 1'b1;
      idle(10);
      for (int i = 0; i < 2; i++) begin
        burst[i] = 8'($urandom);
        send(burst[i], bit_clks(div));
      end
      idle(bit_clks(div));
      for (int i = 0; i < 2; i++) pop_check(burst[i], "R1 divider byte");
    end

    // R8 overflow: nine frames, ninth dropped
    rx_en = 1'b0;
    idle(2);
    div = 16'd1;
    rx_en = 1'b1;
    idle(10);
    for (int i = 0; i < 9; i++) begin
      ov[i] = 8'($urandom);
      send(ov[i], 12);
    end
    idle(24);
    check(ovf, "R8 ovf set", ovf, 1);
    check(irq, "R10 irq on ovf", irq, 1);
    for (int i = 0; i < 8; i++) pop_check(ov[i], "R7 fifo order");
    check(!not_empty, "R8 ninth dropped", not_empty, 0);
    check(ovf, "R8 ovf sticky", ovf, 1);
    clr_ovf = 1'b1;
    @(negedge clk);
    clr_ovf = 1'b0;
    check(!ovf, "R8 ovf cleared", ovf, 0);
    check(!irq, "R10 irq low", irq, 0);

    // R9 underflow
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check(unf, "R9 unf set", unf, 1);
    check(irq, "R10 irq on unf", irq, 1);
    idle(3);
    check(unf, "R9 unf sticky", unf, 1);
    clr_unf = 1'b1;
    @(negedge clk);
    clr_unf = 1'b0;
    check(!unf, "R9 unf cleared", unf, 0);
    check(!irq, "R10 irq cleared", irq, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule